// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port reached through a simple register interface (address, write enable, write data, read enable, read data). Software sets each pin's driven value and whether the pin drives its pad. It can read back the synchronized level of every pad at any time. Each pin also feeds an interrupt detector that can fire on a low level, a high level, a rising edge or a falling edge.

Detected events set a sticky per-pin status bit. Software clears a status bit by writing a one to it. A mask register chooses which status bits reach the interrupt lines. There are two request lines: one for the lower half of the pins and one for the upper half. A third line is the OR of the two, so a system can use either the split lines or the combined one.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register holds zero, `pad_out`, `pad_oe`, `rd_data` and the three interrupt lines are zero, and every pin is masked.
- R2: `pad_out` follows the output-value register at offset 0x00 and `pad_oe` follows the direction register at offset 0x04. A write to either register is visible on these pins on the cycle after the write.
- R3: A read of offsets 0x00, 0x04, 0x0C, 0x10, 0x14 or 0x18 returns that register on `rd_data` from the edge that samples `rd_en`. `rd_data` keeps its value while `rd_en` is low.
- R4: Offset 0x08 reads the pad levels after a two-flop synchronizer, whatever each pin's direction. A pad change made before edge k can be read at edge k+2.
- R5: Each pin has a 2-bit trigger code: 0 is low level, 1 is high level, 2 is rising edge, 3 is falling edge. Pins 0 to 15 take their code from offset 0x0C and pins 16 to 31 from offset 0x10. Pin p's code sits at bits 2*(p mod 16)+1 : 2*(p mod 16).
- R6: A level-coded pin sets its status bit on every cycle that its synchronized level matches. If the level still holds after a clear, the bit sets again on the next cycle.
- R7: An edge-coded pin sets its status bit when the synchronized level differs from its value one cycle earlier, in the coded direction.
- R8: Status at offset 0x18 is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. When a clear and a new event for the same bit fall in the same cycle, the bit stays set.
- R9: `irq_lo` is high when any of pins 0 to 15 has both its status bit and its mask bit (offset 0x14) set. `irq_hi` does the same for pins 16 to 31, and `irq_any` is their OR.
- R10: Unmapped offsets (0x1C to 0x1F, and any offset that is not word aligned) read as zero. Writes to them, and writes to the pad-status offset 0x08, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Value driven towards each pad |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Request line for pins 0 to 15 |
| irq_hi | output | 1 | Request line for pins 16 to 31 |
| irq_any | output | 1 | OR of both request lines |

## Verification
The properties assume that `addr`, `wr_en`, `wr_data` and `rd_en` are free of unknowns and stay stable across each rising edge. They also assume that a read and a write never target the same register in the same cycle. The stimulus changes these inputs only just after a rising edge and issues reads and writes as separate one-cycle accesses, so both conditions hold. The pads are treated as fully asynchronous: the bench changes them in any cycle, including the cycle in which a clear is written, to exercise the case where an event and a clear coincide.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned REG_AW = 5;

    // Per-pin trigger code; the numeric values are visible to software.
    typedef enum logic [1:0] {
        TRIG_LEVEL_LO  = 2'd0,
        TRIG_LEVEL_HI  = 2'd1,
        TRIG_EDGE_RISE = 2'd2,
        TRIG_EDGE_FALL = 2'd3
    } trig_e;

    typedef enum logic [2:0] {
        SEL_DOUT = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_PAD  = 3'd2,
        SEL_CFGL = 3'd3,
        SEL_CFGH = 3'd4,
        SEL_MASK = 3'd5,
        SEL_STAT = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
        reg_sel_e s;
        if (a[1:0] != 2'b00) begin
            s = SEL_NONE;
        end else begin
            unique case (a[REG_AW-1:2])
                3'd0:    s = SEL_DOUT;
                3'd1:    s = SEL_DIR;
                3'd2:    s = SEL_PAD;
                3'd3:    s = SEL_CFGL;
                3'd4:    s = SEL_CFGH;
                3'd5:    s = SEL_MASK;
                3'd6:    s = SEL_STAT;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_async,
    output logic [WIDTH-1:0] lvl_now,
    output logic [WIDTH-1:0] lvl_prev
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl_now  = sync_q;
    assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic [PINS-1:0] lvl_now,
    input  logic [PINS-1:0] lvl_prev,
    input  logic [PINS-1:0] cfg_lo,
    input  logic [PINS-1:0] cfg_hi,
    output logic [PINS-1:0] evt
);
    localparam int unsigned HALF = PINS / 2;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        localparam int unsigned FLD = 2 * (p % HALF);
        logic [1:0] code;

        if (p < HALF) begin : g_lo
            assign code = cfg_lo[FLD +: 2];
        end else begin : g_hi
            assign code = cfg_hi[FLD +: 2];
        end

        always_comb begin
            unique case (trig_e'(code))
                TRIG_LEVEL_LO:  evt[p] = ~lvl_now[p];
                TRIG_LEVEL_HI:  evt[p] =  lvl_now[p];
                TRIG_EDGE_RISE: evt[p] =  lvl_now[p] & ~lvl_prev[p];
                TRIG_EDGE_FALL: evt[p] = ~lvl_now[p] &  lvl_prev[p];
                default:        evt[p] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] evt,
    input  logic [PINS-1:0] clr,
    output logic [PINS-1:0] stat
);
    for (genvar p = 0; p < PINS; p++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (evt[p]) begin
                bit_q <= 1'b1;          // a fresh event beats a clear
            end else if (clr[p]) begin
                bit_q <= 1'b0;
            end
        end
        assign stat[p] = bit_q;
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic              wr_en,
    input  logic [PINS-1:0]   wr_data,
    input  logic              rd_en,
    output logic [PINS-1:0]   rd_data,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq_any
);
    localparam int unsigned HALF = PINS / 2;

    reg_sel_e        sel;
    logic [PINS-1:0] dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q;
    logic [PINS-1:0] lvl_now, lvl_prev;
    logic [PINS-1:0] evt_w, clr_w, stat_q, pend_w, rd_mux, rd_q;

    assign sel = decode_addr(addr);

    gpio_pad_sync #(.WIDTH(PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_async (pad_in),
        .lvl_now   (lvl_now),
        .lvl_prev  (lvl_prev)
    );

    gpio_trig_detect #(.PINS(PINS)) u_detect (
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev),
        .cfg_lo   (cfg_lo_q),
        .cfg_hi   (cfg_hi_q),
        .evt      (evt_w)
    );

    assign clr_w = (wr_en && sel == SEL_STAT) ? wr_data : '0;

    gpio_irq_status #(.PINS(PINS)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_w),
        .clr   (clr_w),
        .stat  (stat_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DOUT: dout_q   <= wr_data;
                SEL_DIR:  dir_q    <= wr_data;
                SEL_CFGL: cfg_lo_q <= wr_data;
                SEL_CFGH: cfg_hi_q <= wr_data;
                SEL_MASK: mask_q   <= wr_data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DOUT: rd_mux = dout_q;
            SEL_DIR:  rd_mux = dir_q;
            SEL_PAD:  rd_mux = lvl_now;
            SEL_CFGL: rd_mux = cfg_lo_q;
            SEL_CFGH: rd_mux = cfg_hi_q;
            SEL_MASK: rd_mux = mask_q;
            SEL_STAT: rd_mux = stat_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_mux;
        end
    end

    assign pend_w  = stat_q & mask_q;
    assign irq_lo  = |pend_w[HALF-1:0];
    assign irq_hi  = |pend_w[PINS-1:HALF];
    assign irq_any = irq_lo | irq_hi;
    assign rd_data = rd_q;
    assign pad_out = dout_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] addr,
    input logic              wr_en,
    input logic [PINS-1:0]   wr_data,
    input logic              rd_en,
    input logic [PINS-1:0]   rd_data,
    input logic [PINS-1:0]   pad_oe,
    input logic              irq_any,
    input logic [PINS-1:0]   stat_q,
    input logic [PINS-1:0]   evt
);
    AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && decode_addr(addr) == SEL_DIR) |=> (pad_oe == $past(wr_data))); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R3

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt))); // R6

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && decode_addr(addr) == SEL_STAT)
            |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && decode_addr(addr) == SEL_STAT && wr_data == '1 && evt == '0)
            |=> (stat_q == '0)); // R8

    AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && decode_addr(addr) == SEL_MASK && wr_data == '0) |=> !irq_any); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && decode_addr(addr) == SEL_NONE) |=> (rd_data == '0)); // R10
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pad_oe  (pad_oe),
    .irq_any (irq_any),
    .stat_q  (stat_q),
    .evt     (evt_w)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi, irq_any;

    always #2.5 clk = ~clk;   // 200 MHz

    gpio_irq_port uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    // behavioural reference state
    logic [31:0] m_dout, m_dir, m_cfg_lo, m_cfg_hi, m_mask, m_stat;
    logic [31:0] m_s1, m_s2, m_prev, m_rd;
    logic [31:0] t_ev, t_clr, t_pend;
    logic [1:0]  t_code;

    function automatic logic [31:0] model_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a)
            5'h00:   return m_dout;
            5'h04:   return m_dir;
            5'h08:   return m_s2;
            5'h0C:   return m_cfg_lo;
            5'h10:   return m_cfg_hi;
            5'h14:   return m_mask;
            5'h18:   return m_stat;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dout = 0; m_dir = 0; m_cfg_lo = 0; m_cfg_hi = 0; m_mask = 0;
            m_stat = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_rd = 0;
        end else begin
            for (int p = 0; p < 32; p++) begin
                t_code = (p < 16) ? m_cfg_lo[2*(p%16) +: 2] : m_cfg_hi[2*(p%16) +: 2];
                case (t_code)
                    2'd0: t_ev[p] = !m_s2[p];
                    2'd1: t_ev[p] = m_s2[p];
                    2'd2: t_ev[p] = m_s2[p] && !m_prev[p];
                    default: t_ev[p] = !m_s2[p] && m_prev[p];
                endcase
            end
            t_clr = (wr_en && addr == 5'h18) ? wr_data : 32'h0;
            if (rd_en) m_rd = model_read(addr);
            if (wr_en) begin
                case (addr)
                    5'h00: m_dout = wr_data;
                    5'h04: m_dir = wr_data;
                    5'h0C: m_cfg_lo = wr_data;
                    5'h10: m_cfg_hi = wr_data;
                    5'h14: m_mask = wr_data;
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~t_clr) | t_ev;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            t_pend = m_stat & m_mask;
            check("pad_out", pad_out, m_dout);
            check("pad_oe", pad_oe, m_dir);
            check("rd_data", rd_data, m_rd);
            check("irq_lo", {31'b0, irq_lo}, {31'b0, |t_pend[15:0]});
            check("irq_hi", {31'b0, irq_hi}, {31'b0, |t_pend[31:16]});
            check("irq_any", {31'b0, irq_any}, {31'b0, |t_pend});
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a);
        addr = a; rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic rd_all();
        for (int i = 0; i < 8; i++) rd(5'(i * 4));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset values
        phase = "R1";
        @(posedge clk);
        cmp_on = 1'b1;
        repeat (4) cyc();
        rst_n = 1'b1;
        repeat (3) cyc();
        rd_all();

        // R2 and R3: output value and direction, readback
        phase = "R2";
        wr(5'h00, 32'hA5A5_0F0F);
        wr(5'h04, 32'hFFFF_0000);
        phase = "R3";
        rd_all();
        wr(5'h14, 32'h1234_5678);
        rd(5'h14);
        repeat (3) cyc();

        // R4: pad levels are read regardless of direction
        phase = "R4";
        pad_in = 32'hDEAD_BEEF;
        rd(5'h08); rd(5'h08); rd(5'h08);
        pad_in = 32'h0123_4567;
        cyc();
        rd(5'h08); rd(5'h08);

        // R10: unmapped and read-only offsets
        phase = "R10";
        rd(5'h1C); rd(5'h02); rd(5'h1F);
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        wr(5'h06, 32'hFFFF_FFFF);
        rd_all();

        // R5 and R6: high-level trigger on all pins
        phase = "R6";
        wr(5'h14, 32'h0);
        pad_in = 32'h0;
        wr(5'h0C, 32'h5555_5555);
        wr(5'h10, 32'h5555_5555);
        repeat (3) cyc();
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        pad_in = 32'h0010_0008;
        repeat (4) cyc();
        rd(5'h18);
        // R8: clear while level still holds, then after level drops
        phase = "R8";
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18);
        pad_in = 32'h0;
        repeat (3) cyc();
        wr(5'h18, 32'h0000_0008);
        rd(5'h18);
        wr(5'h18, 32'h0);
        rd(5'h18);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18);

        // R7: rising edges on low half, falling on high half
        phase = "R7";
        wr(5'h0C, 32'hAAAA_AAAA);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        pad_in = 32'hFFFF_FFFF;
        repeat (4) cyc();
        rd(5'h18);
        wr(5'h18, 32'hFFFF_FFFF);
        pad_in = 32'h0000_0000;
        repeat (4) cyc();
        rd(5'h18);

        // R9: mask only one half at a time
        phase = "R9";
        wr(5'h14, 32'h0000_FFFF);
        repeat (2) cyc();
        wr(5'h14, 32'hFFFF_0000);
        repeat (2) cyc();
        wr(5'h14, 32'h0);
        cyc();

        // R5: mixed per-pin codes under random pads, clears and masks
        phase = "R5";
        wr(5'h0C, 32'h1B1B_E4E4);
        wr(5'h10, 32'h9C63_27D8);
        for (int n = 0; n < 800; n++) begin
            pad_in = pad_in ^ ($urandom & $urandom);
            case ($urandom % 8)
                0: begin addr = 5'h18; wr_data = $urandom; wr_en = 1'b1; end
                1: begin addr = 5'h18; rd_en = 1'b1; end
                2: begin addr = 5'h14; wr_data = $urandom; wr_en = 1'b1; end
                3: begin addr = 5'h08; rd_en = 1'b1; end
                4: begin addr = 5'h0C + 5'(4 * ($urandom % 2)); wr_data = $urandom; wr_en = 1'b1; end
                default: ;
            endcase
            cyc();
            wr_en = 1'b0;
            rd_en = 1'b0;
        end
        repeat (4) cyc();
        finish_run();
    end
endmodule